// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Sleep Handling

This block controls an 8-bit successive-approximation converter inside a small microcontroller. Software writes one 6-bit control register. It holds an enable bit, a start/busy bit, a 2-bit conversion clock select, an interrupt enable and an interrupt flag. After a start, the block steps through one bit trial per conversion-clock period, from the most significant bit down. It drives the trial code to the converter's DAC and reads back a one-bit comparator decision. When the last trial is done, it loads the result register, drops the busy bit and sets the interrupt flag.

The conversion clock comes either from the system clock through a divider or from a separate RC-clock enable input. How the block reacts to the core's sleep request depends on that choice. On the RC clock, a conversion carries on through sleep and can wake the core. On a divided clock, sleep aborts the conversion and powers the converter down. In both cases the enable bit keeps reading back as set. A reset aborts any conversion, but the result register keeps its contents.

Top module: `sar_sequencer`

## Requirements
- R1: After reset the control readback is 0 (disabled, idle, select 00, interrupt enable and flag clear) and the converter is reported unpowered. The result register keeps its contents through reset.
- R2: Control bit layout: bit 0 enable, bit 1 start/busy, bits 3:2 clock select, bit 4 interrupt enable, bit 5 interrupt flag. Writing 1 to bit 1 starts a conversion only if the enable bit was already set before that write and no conversion is running. Otherwise the write leaves busy at 0 or leaves the running conversion untouched.
- R3: Select values 00, 01 and 10 derive the conversion clock from the system clock divided by 2, 8 and 32. The busy bit falls exactly 8 × divisor clock edges after the edge that accepted the start.
- R4: Select 11 picks the RC clock. The block first waits INSTR_CYC system clocks (default 4), then runs one trial on each clock edge where the RC enable input is high. With the RC enable input held high, busy falls INSTR_CYC + 8 edges after the start edge.
- R5: Bits are resolved from MSB to LSB. Each trial bit is set and then kept when the comparator input is 1 or cleared when it is 0. With a comparator that reports input ≥ trial code, the result equals the input code over the full range 00h to FFh.
- R6: At the edge that completes the last trial, busy clears, the interrupt flag sets and the 8-bit result is loaded, all together.
- R7: The interrupt flag stays set until software writes 0 to bit 5. A write with bit 5 at 1 leaves it unchanged. The interrupt output is the flag ANDed with the interrupt enable.
- R8: A sleep request while enabled on a divided clock aborts any conversion and powers the converter off. In that case busy clears, the flag stays as it was, the result is unchanged and the enable bit still reads 1.
- R9: On the RC clock a conversion continues through sleep. If it completes while asleep, the wake request goes high when the interrupt is enabled. When the interrupt is disabled, the converter powers off while the enable bit still reads 1.
- R10: An accepted start brings a powered-off converter back up without the enable bit being cleared and set again.
- R11: Writing 0 to the enable bit during a conversion aborts it without setting the flag or touching the result.
- R12: A reset during a conversion aborts it, and the result register keeps the value from the last completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous device reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 6 | Control register write data |
| sleepReq | input | 1 | Core is asleep (level) |
| rcTick | input | 1 | RC conversion clock enable, one trial per high cycle |
| cmpIn | input | 1 | Comparator decision, 1 when input ≥ trial code |
| ctrlRd | output | 6 | Control register readback |
| result | output | 8 | Last completed conversion result |
| trialCode | output | 8 | Code driven to the DAC during trials |
| convPowered | output | 1 | Converter is enabled and not powered down |
| irq | output | 1 | Interrupt request (flag and enable) |
| wakeReq | output | 1 | Wake-up request to the sleeping core |

## Verification
The bench builds the block with its defaults: 8-bit data, a 4-cycle instruction wait, and divisors of 2, 8 and 32. At these settings every clock select finishes within a few hundred cycles, so all four can be timed exactly against their expected edge counts. An ideal comparator in the bench reports input ≥ trial code, so the all-zero, all-one and mixed input codes each show up directly in the result. The short divided periods also leave time to place a sleep request, an enable clear or a reset inside a running conversion and to see the abort at the ports.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam logic [1:0] RC_SEL = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_TRIAL = 2'd2
  } seqPhase_t;

  typedef struct packed {
    logic startConv;
    logic trialStep;
    logic loadRes;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int INSTR_CYC     = 4,
  parameter int DIV_BASE_LOG2 = 1,
  parameter int DIV_STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [5:0] wrData,
  input  logic       sleepReq,
  input  logic       rcTick,
  input  logic       lastTrial,
  output seqStrobe_t strobe,
  output logic [5:0] ctrlRd,
  output logic       convPowered
);
  localparam int DIV_W  = DIV_BASE_LOG2 + 2 * DIV_STEP_LOG2;
  localparam int WAIT_W = $clog2(INSTR_CYC + 1);

  logic adOn, busy, intEn, intFlag, offQ;
  logic [1:0] sel;
  seqPhase_t phase;
  logic [DIV_W-1:0] divCnt, divLimit;
  logic [WAIT_W-1:0] waitCnt;

  logic useRc, tick, sleepKill, disableNow, abortNow, wrStart;

  function automatic logic [DIV_W-1:0] limitFor(input logic [1:0] s);
    int expo;
    expo = DIV_BASE_LOG2 + DIV_STEP_LOG2 * int'(s);
    return DIV_W'((1 << expo) - 1);
  endfunction

  always_comb begin
    divLimit   = limitFor(sel);
    useRc      = (sel == RC_SEL);
    tick       = (phase == PH_TRIAL) && (useRc ? rcTick : (divCnt == divLimit));
    sleepKill  = sleepReq && adOn && !useRc;
    disableNow = wrEn && !wrData[0];
    abortNow   = busy && (sleepKill || disableNow);
    wrStart    = wrEn && wrData[1] && adOn && !busy;
    strobe.startConv = wrStart && !sleepKill && !disableNow;
    strobe.trialStep = tick && !abortNow;
    strobe.loadRes   = strobe.trialStep && lastTrial;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adOn    <= 1'b0;
      busy    <= 1'b0;
      intEn   <= 1'b0;
      intFlag <= 1'b0;
      offQ    <= 1'b0;
      sel     <= 2'b00;
      phase   <= PH_IDLE;
      divCnt  <= '0;
      waitCnt <= '0;
    end else begin
      if (wrEn) begin
        adOn  <= wrData[0];
        sel   <= wrData[3:2];
        intEn <= wrData[4];
        if (!wrData[5]) intFlag <= 1'b0;
      end
      if (sleepKill) offQ <= 1'b1;
      if (phase == PH_TRIAL && !useRc)
        divCnt <= (divCnt == divLimit) ? '0 : divCnt + 1'b1;
      if (phase == PH_WAIT) begin
        if (waitCnt == WAIT_W'(INSTR_CYC - 1)) begin
          phase  <= PH_TRIAL;
          divCnt <= '0;
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
      end
      if (abortNow) begin
        busy  <= 1'b0;
        phase <= PH_IDLE;
      end else if (strobe.startConv) begin
        busy    <= 1'b1;
        offQ    <= 1'b0;
        phase   <= (wrData[3:2] == RC_SEL) ? PH_WAIT : PH_TRIAL;
        divCnt  <= '0;
        waitCnt <= '0;
      end else if (strobe.loadRes) begin
        busy    <= 1'b0;
        phase   <= PH_IDLE;
        intFlag <= 1'b1;
        if (sleepReq && !intEn) offQ <= 1'b1;
      end
    end
  end

  assign ctrlRd      = {intFlag, intEn, sel, busy, adOn};
  assign convPowered = adOn && !offQ;
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmpIn,
  output logic              lastTrial,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] code, mask, resolved;

  assign resolved  = cmpIn ? code : (code & ~mask);
  assign lastTrial = mask[0];
  assign trialCode = code;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code <= '0;
      mask <= '0;
    end else if (strobe.startConv) begin
      code <= TOP_BIT;
      mask <= TOP_BIT;
    end else if (strobe.trialStep) begin
      code <= resolved | (mask >> 1);
      mask <= mask >> 1;
    end
  end

  // result has no reset: it survives a device reset
  always_ff @(posedge clk) begin
    if (strobe.loadRes) result <= resolved;
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int INSTR_CYC     = 4,
  parameter int DIV_BASE_LOG2 = 1,
  parameter int DIV_STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [5:0]        wrData,
  input  logic              sleepReq,
  input  logic              rcTick,
  input  logic              cmpIn,
  output logic [5:0]        ctrlRd,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] trialCode,
  output logic              convPowered,
  output logic              irq,
  output logic              wakeReq
);
  seqStrobe_t strobe;
  logic lastTrial;

  sar_seq_ctrl #(
    .INSTR_CYC(INSTR_CYC), .DIV_BASE_LOG2(DIV_BASE_LOG2), .DIV_STEP_LOG2(DIV_STEP_LOG2)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .sleepReq(sleepReq),
    .rcTick(rcTick), .lastTrial(lastTrial), .strobe(strobe), .ctrlRd(ctrlRd),
    .convPowered(convPowered)
  );

  sar_seq_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn), .lastTrial(lastTrial),
    .trialCode(trialCode), .result(result)
  );

  assign irq     = ctrlRd[5] && ctrlRd[4];
  assign wakeReq = irq && sleepReq;
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [5:0]        wrData,
  input logic              sleepReq,
  input logic [5:0]        ctrlRd,
  input logic [DATA_W-1:0] result,
  input logic              convPowered,
  input logic              irq,
  input logic              wakeReq
);
  p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[1] && !ctrlRd[0]) |=> !ctrlRd[1]);

  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlRd[1]) && !ctrlRd[1] && !$past(wrEn) &&
     !($past(sleepReq) && $past(ctrlRd[3:2]) != 2'b11)) |-> ctrlRd[5]);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[5] && !(wrEn && !wrData[5])) |=> ctrlRd[5]);

  p_sleep_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && ctrlRd[0] && ctrlRd[3:2] != 2'b11 && !wrEn) |=>
      (ctrlRd[0] && !ctrlRd[1] && !convPowered));

  p_wake_in_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (sleepReq && irq));

  p_result_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRd[1] |=> $stable(result));
endmodule

bind sar_sequencer sar_sequencer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .sleepReq(sleepReq),
  .ctrlRd(ctrlRd), .result(result), .convPowered(convPowered), .irq(irq),
  .wakeReq(wakeReq)
);

// File: tb/sar_sequencer_tb.sv
`timescale 1ns/1ps
module sar_sequencer_tb_top;
  localparam int INSTR = 4;
  localparam logic [5:0] EN = 6'h01, GO = 6'h02, IE = 6'h10, KEEPF = 6'h20;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, sleepReq = 1'b0, rcTick = 1'b0;
  logic [5:0] wrData = '0;
  logic [7:0] vin = 8'h00;
  logic cmpIn;
  logic [5:0] ctrlRd;
  logic [7:0] result, trialCode;
  logic convPowered, irq, wakeReq;

  int nChecks = 0, nFails = 0, cycles = 0, rcMode = 0, rcPh = 0;

  always #2.5 clk = ~clk;

  assign cmpIn = (vin >= trialCode);

  sar_sequencer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .sleepReq(sleepReq),
    .rcTick(rcTick), .cmpIn(cmpIn), .ctrlRd(ctrlRd), .result(result),
    .trialCode(trialCode), .convPowered(convPowered), .irq(irq), .wakeReq(wakeReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mOn, mBusy, mIe, mFlag, mOff, mRc, mResKnown;
  int mSel, mRemain, mWait, mSteps;
  logic [7:0] mRes;

  always @(posedge clk) begin
    if (!rstN) begin
      mOn = 0; mBusy = 0; mIe = 0; mFlag = 0; mOff = 0; mSel = 0;
    end else begin
      bit kill, dis, abortIt, startIt, doneIt;
      kill = sleepReq && mOn && mSel != 3;
      dis = wrEn && !wrData[0];
      abortIt = mBusy && (kill || dis);
      startIt = wrEn && wrData[1] && mOn && !mBusy && !kill && !dis;
      doneIt = 0;
      if (mBusy && !abortIt) begin
        if (!mRc) begin
          mRemain--;
          doneIt = (mRemain == 0);
        end else if (mWait > 0) mWait--;
        else if (rcTick) begin
          mSteps++;
          doneIt = (mSteps == 8);
        end
      end
      if (wrEn) begin
        mOn = wrData[0]; mSel = int'(wrData[3:2]); mIe = wrData[4];
        if (!wrData[5]) mFlag = 0;
      end
      if (kill) mOff = 1;
      if (abortIt) mBusy = 0;
      else if (startIt) begin
        mBusy = 1; mOff = 0; mRc = (mSel == 3);
        mRemain = 8 * (1 << (1 + 2 * mSel)); mWait = INSTR; mSteps = 0;
      end else if (doneIt) begin
        mBusy = 0; mFlag = 1; mRes = vin; mResKnown = 1;
        if (sleepReq && !mIe) mOff = 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R6 ctrl", int'(ctrlRd), int'({mFlag, mIe, mSel[1:0], mBusy, mOn}));
    chk("R8 powered", int'(convPowered), int'(mOn && !mOff));
    chk("R7 irq", int'(irq), int'(mFlag && mIe));
    chk("R9 wake", int'(wakeReq), int'(mFlag && mIe && sleepReq));
    if (mResKnown) chk("R5 result", int'(result), int'(mRes));
    rcPh++;
    rcTick <= (rcMode == 1) || (rcMode == 2 && rcPh % 3 == 0);
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] d);
    @(negedge clk); #1; wrEn = 1; wrData = d;
    @(negedge clk); #1; wrEn = 0;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (ctrlRd[1] && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic timed(input int s, input logic [7:0] v, input int expN, input string req);
    int n;
    vin = v;
    wr(EN | 6'(s << 2));
    wr(EN | GO | 6'(s << 2));
    waitDone(n);
    chk(req, n, expN);
    #1 chk("R5 code", int'(result), int'(v));
  endtask

  initial begin
    int n;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    chk("R1 ctrl", int'(ctrlRd), 0);
    chk("R1 powered", int'(convPowered), 0);
    // R2: start while disabled, and enable+start in one write
    wr(GO); chk("R2 busy", int'(ctrlRd[1]), 0);
    wr(EN | GO); chk("R2 busy", int'(ctrlRd[1]), 0);
    // R3 timing, R5 codes
    timed(0, 8'hA5, 16, "R3 sel0");
    timed(1, 8'h00, 64, "R3 sel1");
    timed(2, 8'hFF, 256, "R3 sel2");
    // R2: start during a conversion does not restart
    vin = 8'h3C; wr(EN | 6'h04); wr(EN | GO | 6'h04);
    repeat (20) @(negedge clk); #1;
    wr(EN | GO | 6'h04 | KEEPF);
    waitDone(n); chk("R2 no restart", n, 64 - 22);
    // R7 flag behaviour
    wr(EN | IE | KEEPF); chk("R7 keep", int'(ctrlRd[5]), 1);
    chk("R7 irq", int'(irq), 1);
    wr(EN); chk("R7 clear", int'(ctrlRd[5]), 0);
    // R4 RC timing with tick held high
    rcMode = 1;
    timed(3, 8'h81, INSTR + 8, "R4 rc");
    // R9 RC through sleep with interrupt enabled
    rcMode = 2; vin = 8'h5A;
    wr(EN | IE | 6'h0C); wr(EN | IE | GO | 6'h0C);
    sleepReq = 1;
    waitDone(n); #1;
    chk("R9 wake", int'(wakeReq), 1);
    chk("R9 result", int'(result), 8'h5A);
    sleepReq = 0; wr(EN | 6'h0C);
    // R9 RC through sleep without interrupt: powers off
    vin = 8'h17; wr(EN | GO | 6'h0C);
    sleepReq = 1;
    waitDone(n); #1;
    chk("R9 off", int'(convPowered), 0);
    chk("R9 enable", int'(ctrlRd[0]), 1);
    sleepReq = 0;
    // R10 start re-powers
    wr(EN | GO | 6'h0C); chk("R10 powered", int'(convPowered), 1);
    waitDone(n); wr(EN | 6'h04);
    // R8 sleep aborts a divided-clock conversion
    keep = result; vin = 8'hC3;
    wr(EN | GO | 6'h04);
    repeat (10) @(negedge clk); #1;
    sleepReq = 1; @(negedge clk); #1; sleepReq = 0;
    chk("R8 busy", int'(ctrlRd[1]), 0);
    chk("R8 enable", int'(ctrlRd[0]), 1);
    chk("R8 flag", int'(ctrlRd[5]), 0);
    chk("R8 powered", int'(convPowered), 0);
    repeat (70) @(negedge clk); #1;
    chk("R8 result", int'(result), int'(keep));
    wr(EN | GO | 6'h04); chk("R10 powered", int'(convPowered), 1);
    waitDone(n); #1 chk("R10 result", int'(result), 8'hC3);
    // R11 clearing enable aborts
    wr(EN | 6'h04); vin = 8'h66; wr(EN | GO | 6'h04);
    repeat (5) @(negedge clk);
    wr(6'h04);
    chk("R11 busy", int'(ctrlRd[1]), 0);
    repeat (70) @(negedge clk); #1;
    chk("R11 flag", int'(ctrlRd[5]), 0);
    chk("R11 result", int'(result), 8'hC3);
    // R12 reset mid-conversion keeps result
    wr(EN | 6'h08); vin = 8'h99; wr(EN | GO | 6'h08);
    repeat (30) @(negedge clk); #1;
    rstN = 0; repeat (2) @(negedge clk); #1; rstN = 1;
    chk("R12 ctrl", int'(ctrlRd), 0);
    repeat (300) @(negedge clk); #1;
    chk("R12 result", int'(result), 8'hC3);
    chk("R1 powered", int'(convPowered), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule